// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Controller

This block keeps watch over the integrity of a copper twisted-pair link in a fiber-to-copper converter. While no frame is being sent on the copper side, it requests a short link test pulse at a fixed interval. On the receive side it takes a strobe for each detected link pulse, with a tag giving its polarity, and a strobe for each received packet. From these it keeps a pass or fail state. A link in fail blocks transmit and receive data through two enable gates.

If no correctly polarised pulse and no packet arrives within the loss window, the link fails. The controller leaves fail after one packet, or after five consecutive good pulses. Pulses that come too close together count as noise. Pulses that come too far apart start a new run. The exit happens only when transmit and receive are both idle. A disable input turns link testing off altogether.

A variant parameter decides whether link fail also stops the optical idle signal, so that a copper disconnect is passed on to the fiber side. All timing windows are cycle-count parameters.

Top module: `lic_link_ctrl`

## Requirements
- R1: With `tx_busy` low and testing enabled, `tx_lp_req` rises once every `LP_PERIOD` cycles and stays high for `LP_WIDTH` cycles each time.
- R2: `tx_lp_req` is low in every cycle after one in which `tx_busy` was high. After `tx_busy` is released, the first request starts only after a full `LP_PERIOD` cycles of silence.
- R3: In pass, if `LOSS_CYCLES` clock edges go by after the last valid pulse or packet with no new one, `link_fail` goes high on that edge.
- R4: After reset, `link_fail` is 1, `tx_lp_req` is 0 and both data enables are 0.
- R5: A packet received during fail brings the link back to pass. The exit takes place only on an edge where `tx_busy` and `rx_busy` are both low, and until then the link stays in fail.
- R6: A valid pulse is one with `rx_lp_strobe` high and `rx_lp_pol_ok` = 1 (correct polarity). Five consecutive valid pulses, each spaced from the previous valid pulse by between `MIN_GAP` and `MAX_GAP` cycles inclusive, end fail on the edge of the fifth.
- R7: A valid pulse spaced fewer than `MIN_GAP` cycles after the previous valid pulse resets the consecutive count to zero. That pulse then becomes the reference for the next spacing.
- R8: A valid pulse spaced more than `MAX_GAP` cycles after the previous one, or the first one after reset or disable, restarts the count at one.
- R9: A pulse with `rx_lp_pol_ok` = 0 is ignored. It neither counts toward recovery nor refreshes the loss window.
- R10: While `lt_disable` is 1, `link_fail` is 0 and `tx_lp_req` stays low.
- R11: `tx_data_en` and `rx_data_en` equal the inverse of `link_fail`. With `FWD_DISCONNECT` = 1, `opt_idle_en` is low during fail; with 0 it is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_busy | input | 1 | Copper transmit is sending a frame |
| rx_busy | input | 1 | Copper receive is taking in a frame |
| lt_disable | input | 1 | Turns link testing off |
| rx_lp_strobe | input | 1 | One-cycle strobe for a detected link pulse |
| rx_lp_pol_ok | input | 1 | Polarity tag of that pulse, 1 = correct |
| rx_pkt_strobe | input | 1 | One-cycle strobe for a received packet |
| tx_lp_req | output | 1 | Request to the line driver to send a link pulse |
| link_fail | output | 1 | Link in fail state, active high |
| tx_data_en | output | 1 | Copper transmit data allowed |
| rx_data_en | output | 1 | Copper receive data allowed |
| opt_idle_en | output | 1 | Optical idle allowed |

## Verification
The bench goes after the spacing edges of recovery: noise pulses inside a run, late pulses that must restart the count rather than extend it, and wrong-polarity pulses mixed in. A design that counted from the last pulse of any polarity, or saturated the count the wrong way, would recover one pulse early or late. Exact cycle checks on the loss edge and on the first request after a busy period would expose an off-by-one counter. A packet held back by `rx_busy` would expose an exit that ignores idle. Both variants run side by side to tell whether optical idle is gated by the parameter.

// File: rtl/lic_pkg.sv
package lic_pkg;

    typedef enum logic {
        LINK_UP   = 1'b0,
        LINK_DOWN = 1'b1
    } link_state_e;

    typedef enum logic [1:0] {
        SP_FIRST,
        SP_NOISE,
        SP_GOOD,
        SP_LATE
    } spacing_e;

    localparam int unsigned RECOVER_PULSES = 5;

    // Sort the spacing between two valid pulses into a window class.
    function automatic spacing_e classify_gap(input logic seen,
                                              input int unsigned gap,
                                              input int unsigned lo,
                                              input int unsigned hi);
        if (!seen)          return SP_FIRST;
        else if (gap < lo)  return SP_NOISE;
        else if (gap > hi)  return SP_LATE;
        else                return SP_GOOD;
    endfunction

endpackage

// File: rtl/lic_pulse_gen.sv
module lic_pulse_gen #(
    parameter int unsigned PERIOD = 2_000_000,
    parameter int unsigned WIDTH  = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic req
);
    localparam int unsigned CW = $clog2(PERIOD);
    localparam int unsigned WW = $clog2(WIDTH + 1);

    logic [CW-1:0] cnt_q;
    logic [WW-1:0] wid_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q <= '0;
            wid_q <= '0;
        end else if (cnt_q == CW'(PERIOD - 1)) begin
            cnt_q <= '0;
            wid_q <= WW'(WIDTH);
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (wid_q != '0)
                wid_q <= wid_q - 1'b1;
        end
    end

    assign req = (wid_q != '0);

    // R2: a busy or disabled cycle silences the request on the next cycle
    a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !req);

    generate
        if (WIDTH > 1) begin : g_width
            // R1: a request lasts beyond its first cycle while enabled
            a_r1_width_hold: assert property (@(posedge clk) disable iff (rst)
                ($rose(req) && enable) |=> req);
        end
    endgenerate

endmodule

// File: rtl/lic_spacing_tracker.sv
module lic_spacing_tracker
    import lic_pkg::*;
#(
    parameter int unsigned MIN_GAP    = 500_000,
    parameter int unsigned MAX_GAP    = 6_250_000,
    parameter int unsigned RUN_TARGET = RECOVER_PULSES
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic lp_valid,
    output logic run_done
);
    localparam int unsigned GW = $clog2(MAX_GAP + 2);
    localparam int unsigned RW = $clog2(RUN_TARGET + 1);
    localparam logic [GW-1:0] GAP_SAT = GW'(MAX_GAP + 1);

    logic [GW-1:0] gap_q;
    logic          seen_q;
    logic [RW-1:0] run_q, run_d;
    spacing_e      cls;

    always_comb begin
        cls   = classify_gap(seen_q, int'(gap_q), MIN_GAP, MAX_GAP);
        run_d = run_q;
        case (cls)
            SP_FIRST, SP_LATE: run_d = RW'(1);
            SP_NOISE:          run_d = '0;
            default:           run_d = (run_q == RW'(RUN_TARGET)) ? run_q : run_q + 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            run_q  <= '0;
        end else if (lp_valid) begin
            gap_q  <= GW'(1);
            seen_q <= 1'b1;
            run_q  <= run_d;
        end else if (gap_q != GAP_SAT) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assign run_done = lp_valid && (run_d == RW'(RUN_TARGET));

    // R6: the run count never passes its target
    a_r6_run_bound: assert property (@(posedge clk) disable iff (rst)
        run_q <= RW'(RUN_TARGET));

    // R8: a pulse after a saturated gap restarts the run at one
    a_r8_late_restart: assert property (@(posedge clk) disable iff (rst)
        (lp_valid && !clear && seen_q && gap_q == GAP_SAT) |=> run_q == RW'(1));

    // R7: a pulse inside the noise window empties the run
    a_r7_noise_zero: assert property (@(posedge clk) disable iff (rst)
        (lp_valid && !clear && seen_q && gap_q < GW'(MIN_GAP)) |=> run_q == '0);

endmodule

// File: rtl/lic_link_fsm.sv
module lic_link_fsm
    import lic_pkg::*;
#(
    parameter int unsigned LOSS_CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic lt_disable,
    input  logic activity,
    input  logic recover_now,
    input  logic tx_busy,
    input  logic rx_busy,
    output logic link_fail
);
    localparam int unsigned LW = $clog2(LOSS_CYCLES);
    localparam logic [LW-1:0] LOSS_LAST = LW'(LOSS_CYCLES - 1);

    link_state_e   state_q;
    logic [LW-1:0] loss_q;
    logic          pend_q;
    logic          both_idle;

    assign both_idle = !tx_busy && !rx_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LINK_DOWN;
            loss_q  <= '0;
            pend_q  <= 1'b0;
        end else if (lt_disable) begin
            state_q <= LINK_UP;
            loss_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (activity)
                loss_q <= '0;
            else if (loss_q != LOSS_LAST)
                loss_q <= loss_q + 1'b1;

            case (state_q)
                LINK_UP: begin
                    if (!activity && loss_q == LOSS_LAST) begin
                        state_q <= LINK_DOWN;
                        pend_q  <= 1'b0;
                    end
                end
                default: begin
                    if ((pend_q || recover_now) && both_idle) begin
                        state_q <= LINK_UP;
                        pend_q  <= 1'b0;
                        loss_q  <= '0;
                    end else if (recover_now) begin
                        pend_q  <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign link_fail = (state_q == LINK_DOWN) && !lt_disable;

    // R3: activity while passing keeps the link passing
    a_r3_activity_keeps_up: assert property (@(posedge clk) disable iff (rst)
        (state_q == LINK_UP && activity && !lt_disable) |=> state_q == LINK_UP);

    // R5: no exit from fail while either direction is busy
    a_r5_busy_holds_fail: assert property (@(posedge clk) disable iff (rst)
        (state_q == LINK_DOWN && !both_idle && !lt_disable) |=> state_q == LINK_DOWN);

    // R10: disable leaves the link passing on the next cycle
    a_r10_disable_passes: assert property (@(posedge clk) disable iff (rst)
        lt_disable |=> state_q == LINK_UP);

endmodule

// File: rtl/lic_link_ctrl.sv
module lic_link_ctrl
    import lic_pkg::*;
#(
    parameter int unsigned LP_PERIOD      = 2_000_000,
    parameter int unsigned LP_WIDTH       = 15,
    parameter int unsigned LOSS_CYCLES    = 12_500_000,
    parameter int unsigned MIN_GAP        = 500_000,
    parameter int unsigned MAX_GAP        = 6_250_000,
    parameter bit          FWD_DISCONNECT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_busy,
    input  logic rx_busy,
    input  logic lt_disable,
    input  logic rx_lp_strobe,
    input  logic rx_lp_pol_ok,
    input  logic rx_pkt_strobe,
    output logic tx_lp_req,
    output logic link_fail,
    output logic tx_data_en,
    output logic rx_data_en,
    output logic opt_idle_en
);
    logic lp_valid;
    logic run_done;
    logic activity;
    logic recover_now;

    assign lp_valid    = rx_lp_strobe && rx_lp_pol_ok && !lt_disable;
    assign activity    = lp_valid || rx_pkt_strobe;
    assign recover_now = run_done || rx_pkt_strobe;

    lic_pulse_gen #(
        .PERIOD (LP_PERIOD),
        .WIDTH  (LP_WIDTH)
    ) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .enable (!tx_busy && !lt_disable),
        .req    (tx_lp_req)
    );

    lic_spacing_tracker #(
        .MIN_GAP    (MIN_GAP),
        .MAX_GAP    (MAX_GAP),
        .RUN_TARGET (RECOVER_PULSES)
    ) u_spacing (
        .clk      (clk),
        .rst      (rst),
        .clear    (lt_disable),
        .lp_valid (lp_valid),
        .run_done (run_done)
    );

    lic_link_fsm #(
        .LOSS_CYCLES (LOSS_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .lt_disable  (lt_disable),
        .activity    (activity),
        .recover_now (recover_now),
        .tx_busy     (tx_busy),
        .rx_busy     (rx_busy),
        .link_fail   (link_fail)
    );

    assign tx_data_en = !link_fail;
    assign rx_data_en = !link_fail;

    generate
        if (FWD_DISCONNECT) begin : g_fwd
            assign opt_idle_en = !link_fail;
        end else begin : g_keep
            assign opt_idle_en = 1'b1;
        end
    endgenerate

    // R11: a failing link never lets receive data through
    a_r11_rx_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(link_fail) |-> !rx_data_en);

endmodule

// File: tb/lic_link_ctrl_tb_top.sv
module lic_link_ctrl_tb_top;
    localparam int P    = 40;
    localparam int W    = 3;
    localparam int LOSS = 300;
    localparam int MING = 10;
    localparam int MAXG = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_busy = 1'b1, rx_busy = 1'b0, lt_disable = 1'b0;
    logic rx_lp_strobe = 1'b0, rx_lp_pol_ok = 1'b1, rx_pkt_strobe = 1'b0;
    logic tx_lp_req, link_fail, tx_data_en, rx_data_en, opt_idle_en;
    logic n_req, n_fail, n_txen, n_rxen, n_opt;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    lic_link_ctrl #(.LP_PERIOD(P), .LP_WIDTH(W), .LOSS_CYCLES(LOSS),
                    .MIN_GAP(MING), .MAX_GAP(MAXG), .FWD_DISCONNECT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .tx_busy(tx_busy), .rx_busy(rx_busy),
        .lt_disable(lt_disable), .rx_lp_strobe(rx_lp_strobe),
        .rx_lp_pol_ok(rx_lp_pol_ok), .rx_pkt_strobe(rx_pkt_strobe),
        .tx_lp_req(tx_lp_req), .link_fail(link_fail), .tx_data_en(tx_data_en),
        .rx_data_en(rx_data_en), .opt_idle_en(opt_idle_en));

    lic_link_ctrl #(.LP_PERIOD(P), .LP_WIDTH(W), .LOSS_CYCLES(LOSS),
                    .MIN_GAP(MING), .MAX_GAP(MAXG), .FWD_DISCONNECT(1'b0)) dut_n (
        .clk(clk), .rst(rst), .tx_busy(tx_busy), .rx_busy(rx_busy),
        .lt_disable(lt_disable), .rx_lp_strobe(rx_lp_strobe),
        .rx_lp_pol_ok(rx_lp_pol_ok), .rx_pkt_strobe(rx_pkt_strobe),
        .tx_lp_req(n_req), .link_fail(n_fail), .tx_data_en(n_txen),
        .rx_data_en(n_rxen), .opt_idle_en(n_opt));

    task automatic chk(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_gates();
        chk("R11 tx_data_en", tx_data_en, !link_fail);
        chk("R11 rx_data_en", rx_data_en, !link_fail);
        chk("R11 opt idle fwd", opt_idle_en, !link_fail);
        chk("R11 opt idle keep", n_opt, 1'b1);
        chk("R11 variants agree", n_fail, link_fail);
    endtask

    task automatic send_lp(input int gap, input logic pol);
        repeat (gap - 2) @(negedge clk);
        @(negedge clk);
        rx_lp_strobe = 1'b1;
        rx_lp_pol_ok = pol;
        @(negedge clk);
        rx_lp_strobe = 1'b0;
        rx_lp_pol_ok = 1'b1;
    endtask

    task automatic send_pkt();
        @(negedge clk);
        rx_pkt_strobe = 1'b1;
        @(negedge clk);
        rx_pkt_strobe = 1'b0;
    endtask

    task automatic wait_fail();
        repeat (LOSS + MAXG + 5) @(negedge clk);
        chk("R3 loss to fail", link_fail, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int  run, since, gap, r;
        bit  first, fexp;
        logic pol;
        void'($urandom(32'h5eed_1c0d));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R4 reset state
        chk("R4 fail after reset", link_fail, 1'b1);
        chk("R4 req after reset", tx_lp_req, 1'b0);
        chk_gates();

        // R1 / R2 pulse timing
        @(negedge clk); tx_busy = 1'b0;
        repeat (P - 1) @(negedge clk);
        chk("R2 silence before first pulse", tx_lp_req, 1'b0);
        @(negedge clk);
        chk("R1 pulse starts", tx_lp_req, 1'b1);
        repeat (W - 1) @(negedge clk);
        chk("R1 pulse width held", tx_lp_req, 1'b1);
        @(negedge clk);
        chk("R1 pulse width end", tx_lp_req, 1'b0);
        repeat (P - W - 1) @(negedge clk);
        chk("R1 gap before second", tx_lp_req, 1'b0);
        @(negedge clk);
        chk("R1 period", tx_lp_req, 1'b1);
        @(negedge clk); tx_busy = 1'b1;
        @(negedge clk);
        chk("R2 busy stops pulse", tx_lp_req, 1'b0);
        repeat (2 * P) @(negedge clk);
        chk("R2 no pulse while busy", tx_lp_req, 1'b0);
        tx_busy = 1'b0;

        // R5 packet recovery held by rx_busy
        rx_busy = 1'b1;
        send_pkt();
        repeat (5) @(negedge clk);
        chk("R5 busy holds fail", link_fail, 1'b1);
        rx_busy = 1'b0;
        @(negedge clk);
        chk("R5 packet exit when idle", link_fail, 1'b0);
        chk_gates();

        // R3 exact loss edge
        send_lp(2, 1'b1);
        repeat (LOSS - 1) @(negedge clk);
        chk("R3 still pass before loss", link_fail, 1'b0);
        @(negedge clk);
        chk("R3 fail at loss edge", link_fail, 1'b1);
        chk_gates();

        // R6 five good pulses
        for (int i = 1; i <= 5; i++) begin
            send_lp(30, 1'b1);
            chk("R6 five consecutive", link_fail, (i < 5));
        end

        // R7 noise resets the run
        wait_fail();
        for (int i = 0; i < 3; i++) send_lp(30, 1'b1);
        send_lp(5, 1'b1);
        chk("R7 noise keeps fail", link_fail, 1'b1);
        for (int i = 0; i < 4; i++) send_lp(30, 1'b1);
        chk("R7 count restarted", link_fail, 1'b1);
        send_lp(30, 1'b1);
        chk("R7 recover after fresh run", link_fail, 1'b0);

        // R8 late pulse restarts at one
        wait_fail();
        for (int i = 0; i < 3; i++) send_lp(30, 1'b1);
        send_lp(MAXG + 10, 1'b1);
        for (int i = 0; i < 3; i++) send_lp(30, 1'b1);
        chk("R8 late restarts count", link_fail, 1'b1);
        send_lp(30, 1'b1);
        chk("R8 recover at fifth", link_fail, 1'b0);

        // R9 wrong polarity ignored
        wait_fail();
        for (int i = 0; i < 6; i++) send_lp(30, 1'b0);
        chk("R9 bad polarity no recovery", link_fail, 1'b1);
        send_pkt();
        @(negedge clk);
        chk("R9 pass via packet", link_fail, 1'b0);
        for (int i = 0; i < 7; i++) send_lp(50, 1'b0);
        chk("R9 bad polarity no refresh", link_fail, 1'b1);

        // R10 disable
        lt_disable = 1'b1;
        @(negedge clk);
        begin
            bit bad = 1'b0;
            for (int i = 0; i < 2 * LOSS; i++) begin
                @(negedge clk);
                if (link_fail || tx_lp_req) bad = 1'b1;
            end
            chk("R10 disabled never fails or pulses", bad, 1'b0);
        end
        lt_disable = 1'b0;

        // R6/R7/R8 random trains against a model
        for (int t = 0; t < 20; t++) begin
            wait_fail();
            first = 1'b1; run = 0; since = 0; fexp = 1'b1;
            for (int k = 0; k < 12; k++) begin
                r = $urandom_range(0, 99);
                if (r < 15)      gap = $urandom_range(2, MING - 1);
                else if (r < 30) gap = $urandom_range(MAXG + 1, MAXG + 40);
                else             gap = $urandom_range(MING, MAXG);
                pol = 1'b1;
                if (!first && since < 100 && $urandom_range(0, 9) == 0) pol = 1'b0;
                send_lp(gap, pol);
                if (pol) begin
                    if (first || since + gap > MAXG) run = 1;
                    else if (since + gap < MING)     run = 0;
                    else if (run < 5)                run = run + 1;
                    if (run == 5) fexp = 1'b0;
                    since = 0;
                    first = 1'b0;
                end else begin
                    since = since + gap;
                end
                chk("R6/R7/R8 random train", link_fail, fexp);
            end
            chk_gates();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule